// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt vectors from on-chip sources and stores each one as a 16-byte record in a circular ring in memory. Software reads the records out at its own pace. The write position and the read position are held as byte offsets into the ring, and the ring is empty when the two are equal. The ring starts at a 256-byte aligned base address. Its length is a power of two that software selects through a size field. When a new record lands on the slot that software has not yet consumed, an overflow flag is set. That flag stays set until software clears it.

After each record, the block can also store the current write-position word (offset plus overflow flag) at a second memory address. Software can then poll memory instead of the register. An interrupt line tells software that new records are waiting. A software update of the read position drops that line, or keeps it up when the optional re-arm mode is on and records still remain.

The block is programmed through a small register port with a one-cycle read latency. Vectors enter on a valid/ready handshake. Memory writes leave on a request/acknowledge port that carries either a full 16-byte record or a 4-byte word.

Top module: `ivr_ring_writer`

## Requirements
- R1: After reset, `irq`, `src_ready` and `mem_req` are low. The control, read-offset and write-offset registers read as zero.
- R2: A vector is accepted (`src_ready` high) only when both the ring-enable bit (control bit 0) and the interrupt-enable bit (control bit 1) are set. With either bit clear, `src_valid` produces no memory request.
- R3: An accepted vector is written as one 16-byte request with `mem_wide`=1, address = (base register << 8) + write offset, and data equal to the vector. Once it is acknowledged, the write offset advances by 16, modulo the ring length. The request and its address hold steady until `mem_ack`.
- R4: Control bits [12:8] give log2 of the ring length in 32-bit words. Values below 3 act as 3, and values above the parameter maximum act as that maximum. Both offsets wrap inside the resulting byte length, and read-offset writes are masked to it.
- R5: If (write offset + 16) modulo the length equals the read offset when a vector is accepted, bit 31 of the write-offset register (overflow) becomes set. The vector is still written and the offset still advances. The flag is sticky.
- R6: Writing control with bit 4 set clears the overflow flag. Bit 4 reads back as zero.
- R7: With control bit 2 set, each record acknowledgement is followed by a 4-byte request (`mem_wide`=0) to address {writeback-high[7:0], writeback-low}. Its low data word is the new write-offset register value, overflow in bit 31. With bit 2 clear, no such request is made.
- R8: Clearing the ring-enable bit zeroes both offsets and the overflow flag. Read-offset writes while disabled are ignored.
- R9: `irq` goes high from the clock edge that takes a record acknowledgement, and only while both enable bits are set.
- R10: One cycle after a read-offset write, `irq` drops if the re-arm bit (control bit 3) is clear. With re-arm set, `irq` stays high when the new read offset differs from the write offset and drops when they are equal.
- R11: Register reads return data one cycle after `reg_addr` is presented. The map is: 0 control, 1 base, 2 read offset, 3 write offset (read-only), 4 writeback-low, 5 writeback-high.
- R12: `src_ready` stays low while any memory request, either a record or a writeback, is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| src_valid | input | 1 | Vector offered |
| src_ready | output | 1 | Vector can be accepted |
| src_vec | input | 128 | Vector contents, four 32-bit words |
| mem_req | output | 1 | Memory write request, held until acknowledged |
| mem_wide | output | 1 | 1: 16-byte record, 0: 4-byte writeback in low word |
| mem_addr | output | 40 | Byte address of the write |
| mem_wdata | output | 128 | Write data |
| mem_ack | input | 1 | Memory accepts the current request |
| irq | output | 1 | Interrupt to software |

## Verification
The record request appears in the cycle after the edge that accepts the vector. A writeback request follows in the cycle after the record acknowledgement. `irq` rises on the acknowledging edge itself and reacts to a read-offset write on the second edge after that write. Register reads settle one edge after the address is driven. The bench drives all inputs and samples all outputs on falling edges. Before every comparison it waits exactly those edges: it reads registers one falling edge after setting the address and probes `irq` one extra falling edge after a read-offset write. A scoreboard queue, filled by the vector driver, is compared against each memory request as the responder acknowledges it with varying delays.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int REC_BYTES = 16;
  localparam int WORD_W    = 32;
  localparam int REC_WORDS = 4;
  localparam int ADDR_W    = 40;
  localparam int MIN_L2W   = 3;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_REC, ST_WB} eng_st_e;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int MAX_L2W = 14,
  localparam int PTR_W = MAX_L2W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PTR_W-1:0]  wptr,
  input  logic              ovf,
  output logic              ring_en,
  output logic              irq_en,
  output logic              wb_en,
  output logic              rearm,
  output logic              ovf_clr,
  output logic [PTR_W-1:0]  ring_mask,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  rptr,
  output logic              rptr_upd
);
  logic [4:0]  size_q;
  logic [4:0]  eff_l2w;
  logic [31:0] base_q, wblo_q;
  logic [7:0]  wbhi_q;
  logic [31:0] wptr_word;

  // Clamp the size field, then build the byte mask of the ring.
  always_comb begin
    if (size_q < 5'(MIN_L2W))      eff_l2w = 5'(MIN_L2W);
    else if (size_q > 5'(MAX_L2W)) eff_l2w = 5'(MAX_L2W);
    else                           eff_l2w = size_q;
    for (int i = 0; i < PTR_W; i++) ring_mask[i] = (i < int'(eff_l2w) + 2);
  end

  assign base_addr = {base_q, 8'h00};
  assign wb_addr   = {wbhi_q, wblo_q};

  always_comb begin
    wptr_word     = 32'(wptr);
    wptr_word[31] = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en <= 1'b0; irq_en <= 1'b0; wb_en <= 1'b0; rearm <= 1'b0;
      ovf_clr <= 1'b0; size_q <= '0; base_q <= '0; wblo_q <= '0;
      wbhi_q <= '0; rptr <= '0; rptr_upd <= 1'b0; reg_rdata <= '0;
    end else begin
      ovf_clr  <= 1'b0;
      rptr_upd <= 1'b0;
      if (!ring_en) rptr <= '0;
      if (reg_we) begin
        case (reg_addr)
          RA_CTRL: begin
            ring_en <= reg_wdata[0];
            irq_en  <= reg_wdata[1];
            wb_en   <= reg_wdata[2];
            rearm   <= reg_wdata[3];
            ovf_clr <= reg_wdata[4];
            size_q  <= reg_wdata[12:8];
          end
          RA_BASE: base_q <= reg_wdata;
          RA_RPTR: if (ring_en) begin
            rptr     <= reg_wdata[PTR_W-1:0] & ring_mask;
            rptr_upd <= 1'b1;
          end
          RA_WBLO: wblo_q <= reg_wdata;
          RA_WBHI: wbhi_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      case (reg_addr)
        RA_CTRL: reg_rdata <= {19'h0, size_q, 4'h0, rearm, wb_en, irq_en, ring_en};
        RA_BASE: reg_rdata <= base_q;
        RA_RPTR: reg_rdata <= 32'(rptr);
        RA_WPTR: reg_rdata <= wptr_word;
        RA_WBLO: reg_rdata <= wblo_q;
        RA_WBHI: reg_rdata <= {24'h0, wbhi_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_RPTR_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    !ring_en |=> rptr == '0); // R8
endmodule

// File: rtl/ivr_engine.sv
module ivr_engine
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16,
  localparam int VEC_W = WORD_W * REC_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_en,
  input  logic              irq_en,
  input  logic              wb_en,
  input  logic              ovf_clr,
  input  logic [PTR_W-1:0]  ring_mask,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [VEC_W-1:0]  src_vec,
  output logic              mem_req,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [VEC_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  output logic [PTR_W-1:0]  wptr,
  output logic              ovf,
  output logic              wptr_adv
);
  eng_st_e          st;
  logic             pend_ovf;
  logic [PTR_W-1:0] next_wptr;
  logic [31:0]      wb_word;

  assign next_wptr = (wptr + PTR_W'(REC_BYTES)) & ring_mask;
  assign src_ready = (st == ST_IDLE) && ring_en && irq_en;
  assign wptr_adv  = (st == ST_REC) && mem_ack && ring_en;

  always_comb begin
    wb_word     = 32'(next_wptr);
    wb_word[31] = ovf | pend_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; mem_req <= 1'b0; mem_wide <= 1'b0; mem_addr <= '0;
      mem_wdata <= '0; wptr <= '0; ovf <= 1'b0; pend_ovf <= 1'b0;
    end else begin
      if (!ring_en) begin
        wptr <= '0;
        ovf  <= 1'b0;
      end else begin
        if (wptr_adv) wptr <= next_wptr;
        if (wptr_adv && pend_ovf) ovf <= 1'b1;
        else if (ovf_clr)         ovf <= 1'b0;
      end
      case (st)
        ST_IDLE: if (src_valid && src_ready) begin
          mem_req   <= 1'b1;
          mem_wide  <= 1'b1;
          mem_addr  <= base_addr + ADDR_W'(wptr);
          mem_wdata <= src_vec;
          pend_ovf  <= (next_wptr == rptr);
          st        <= ST_REC;
        end
        ST_REC: if (mem_ack) begin
          if (wb_en) begin
            mem_wide  <= 1'b0;
            mem_addr  <= wb_addr;
            mem_wdata <= VEC_W'(wb_word);
            st        <= ST_WB;
          end else begin
            mem_req <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        ST_WB: if (mem_ack) begin
          mem_req <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> !mem_req); // R12
  AST_WPTR_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ring_en && $past(ring_en) && (wptr != $past(wptr)) |-> $past(mem_req && mem_ack && mem_wide)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr && ring_en |=> ovf); // R5
endmodule

// File: rtl/ivr_irq.sv
module ivr_irq #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ring_en,
  input  logic             irq_en,
  input  logic             rearm,
  input  logic             wptr_adv,
  input  logic             rptr_upd,
  input  logic [PTR_W-1:0] rptr,
  input  logic [PTR_W-1:0] wptr,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst)                       irq <= 1'b0;
    else if (!(ring_en && irq_en)) irq <= 1'b0;
    else if (wptr_adv)             irq <= 1'b1;
    else if (rptr_upd)             irq <= rearm && (rptr != wptr);
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ring_en && irq_en)); // R9
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wptr_adv || rptr_upd)); // R10
endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
  import ivr_pkg::*;
#(
  parameter int MAX_L2W = 14,
  localparam int PTR_W = MAX_L2W + 2,
  localparam int VEC_W = WORD_W * REC_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [VEC_W-1:0]  src_vec,
  output logic              mem_req,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [VEC_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  output logic              irq
);
  logic              ring_en, irq_en, wb_en, rearm, ovf_clr, rptr_upd;
  logic              ovf, wptr_adv;
  logic [PTR_W-1:0]  ring_mask, rptr, wptr;
  logic [ADDR_W-1:0] base_addr, wb_addr;

  ivr_regs #(.MAX_L2W(MAX_L2W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr(wptr), .ovf(ovf),
    .ring_en(ring_en), .irq_en(irq_en), .wb_en(wb_en), .rearm(rearm),
    .ovf_clr(ovf_clr), .ring_mask(ring_mask), .base_addr(base_addr),
    .wb_addr(wb_addr), .rptr(rptr), .rptr_upd(rptr_upd)
  );

  ivr_engine #(.PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst(rst), .ring_en(ring_en), .irq_en(irq_en), .wb_en(wb_en),
    .ovf_clr(ovf_clr), .ring_mask(ring_mask), .rptr(rptr),
    .base_addr(base_addr), .wb_addr(wb_addr), .src_valid(src_valid),
    .src_ready(src_ready), .src_vec(src_vec), .mem_req(mem_req),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .wptr(wptr), .ovf(ovf), .wptr_adv(wptr_adv)
  );

  ivr_irq #(.PTR_W(PTR_W)) u_irq (
    .clk(clk), .rst(rst), .ring_en(ring_en), .irq_en(irq_en), .rearm(rearm),
    .wptr_adv(wptr_adv), .rptr_upd(rptr_upd), .rptr(rptr), .wptr(wptr),
    .irq(irq)
  );
endmodule

// File: tb/ivr_ring_writer_bench.sv
module ivr_ring_writer_bench;
  typedef struct packed {
    logic [39:0]  a;
    logic [127:0] d;
    logic         w;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         src_valid = 1'b0;
  logic         src_ready;
  logic [127:0] src_vec = '0;
  logic         mem_req, mem_wide, mem_ack;
  logic [39:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  // Reference model state
  logic [15:0] wm = '0, rm = '0, mask_m = 16'h001F;
  logic        om = 1'b0, wb_m = 1'b0;
  logic [31:0] base_m = '0;
  logic [39:0] wba_m = '0;

  ivr_ring_writer u_ivr_ring_writer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
    .src_ready(src_ready), .src_vec(src_vec), .mem_req(mem_req),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_of(input logic [4:0] sz);
    int e;
    e = (sz < 3) ? 3 : ((sz > 14) ? 14 : int'(sz));
    return 16'((32'd1 << (e + 2)) - 1);
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    reg_write(3'd0, v);
    mask_m = mask_of(v[12:8]);
    wb_m = v[2];
    if (v[4]) om = 1'b0;
    if (!v[0]) begin wm = '0; rm = '0; om = 1'b0; end
  endtask

  task automatic set_rptr(input logic [31:0] v);
    reg_write(3'd2, v);
    rm = v[15:0] & mask_m;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || mem_req);
    @(negedge clk);
  endtask

  task automatic send(input logic [127:0] v);
    exp_t e;
    logic [15:0] nw;
    logic ov;
    nw = (wm + 16'd16) & mask_m;
    ov = (nw == rm);
    e.a = {base_m, 8'h00} + 40'(wm); e.d = v; e.w = 1'b1;
    q.push_back(e);
    wm = nw;
    if (ov) om = 1'b1;
    if (wb_m) begin
      e.a = wba_m; e.d = {96'h0, om, 15'h0, nw}; e.w = 1'b0;
      q.push_back(e);
    end
    @(negedge clk);
    src_valid = 1'b1; src_vec = v;
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
    wait_idle();
  endtask

  // Monitor / memory responder: pops the scoreboard on every request.
  initial begin
    int dly;
    exp_t e;
    mem_ack = 1'b0;
    dly = 1;
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        repeat (dly) @(negedge clk);
        dly = dly % 3 + 1;
        chk("R12 ready low while request pending", 128'(src_ready), 128'(0));
        if (q.size() == 0) begin
          chk("R2/R7 unexpected memory request", 128'(mem_addr), 128'(0));
          if (mem_addr == 0) chk("R2/R7 unexpected memory request", 128'(1), 128'(0));
        end else begin
          e = q.pop_front();
          chk(e.w ? "R3 record address" : "R7 writeback address", 128'(mem_addr), 128'(e.a));
          chk(e.w ? "R3 record data" : "R7 writeback data", mem_wdata, e.d);
          chk(e.w ? "R3 record width" : "R7 writeback width", 128'(mem_wide), 128'(e.w));
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", 128'(irq), 128'(0));
    chk("R1 src_ready after reset", 128'(src_ready), 128'(0));
    chk("R1 mem_req after reset", 128'(mem_req), 128'(0));
    reg_read(3'd0, rd); chk("R1 control reset", 128'(rd), 128'(0));
    reg_read(3'd2, rd); chk("R1 read offset reset", 128'(rd), 128'(0));
    reg_read(3'd3, rd); chk("R1 write offset reset", 128'(rd), 128'(0));

    // R2 no acceptance while not fully enabled
    @(negedge clk); src_valid = 1'b1; src_vec = 128'hDEAD;
    repeat (4) begin
      @(negedge clk);
      chk("R2 ready with control clear", 128'(src_ready), 128'(0));
    end
    src_valid = 1'b0;
    set_ctrl(32'h0000_0401);
    @(negedge clk); src_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R2 ready with ring only", 128'(src_ready || mem_req), 128'(0));
    end
    src_valid = 1'b0;

    // Setup: base, writeback address, 64-byte ring with writeback
    reg_write(3'd1, 32'h0012_3456); base_m = 32'h0012_3456;
    reg_write(3'd4, 32'h0000_1000);
    reg_write(3'd5, 32'h0000_005A); wba_m = {8'h5A, 32'h0000_1000};
    set_ctrl(32'h0000_0407);
    chk("R9 irq low before any record", 128'(irq), 128'(0));
    send(128'h0000_0001_0000_0002_0000_0003_0000_00A1);
    chk("R9 irq after first record", 128'(irq), 128'(1));
    reg_read(3'd3, rd); chk("R3 write offset after one record", 128'(rd), 128'(16));
    send(128'hB2); send(128'hC3);
    reg_read(3'd3, rd); chk("R3 write offset after three", 128'(rd), 128'(48));
    send(128'hD4);
    reg_read(3'd3, rd); chk("R5 overflow flag and wrap", 128'(rd), 128'(32'h8000_0000));
    send(128'hE5);
    reg_read(3'd3, rd); chk("R5 overflow sticky", 128'(rd), 128'(32'h8000_0010));
    set_ctrl(32'h0000_0417);
    reg_read(3'd3, rd); chk("R6 overflow cleared", 128'(rd), 128'(16));
    reg_read(3'd0, rd); chk("R6 clear bit reads zero", 128'(rd), 128'(32'h0000_0407));

    // R10 interrupt behaviour on read-offset updates
    set_rptr(32'h0); @(negedge clk);
    chk("R10 irq drops without rearm", 128'(irq), 128'(0));
    send(128'hF6);
    chk("R9 irq rises on new record", 128'(irq), 128'(1));
    set_ctrl(32'h0000_040F);
    set_rptr(32'd16); @(negedge clk);
    chk("R10 rearm keeps irq with data left", 128'(irq), 128'(1));
    set_rptr(32'd32); @(negedge clk);
    chk("R10 rearm drops irq when empty", 128'(irq), 128'(0));
    reg_read(3'd2, rd); chk("R11 read offset readback", 128'(rd), 128'(32));
    set_rptr(32'h0000_FFF0);
    reg_read(3'd2, rd); chk("R4 read offset masked to ring", 128'(rd), 128'(32'h30));
    @(negedge clk);
    chk("R10 rearm raises irq for pending data", 128'(irq), 128'(1));
    set_rptr(32'd32);

    // R7 writeback off
    set_ctrl(32'h0000_040B);
    send(128'h77);
    chk("R7 no writeback queued leftover", 128'(q.size()), 128'(0));
    reg_read(3'd3, rd); chk("R3 offset without writeback", 128'(rd), 128'(48));

    // R8 disable clears offsets
    set_ctrl(32'h0000_0400);
    reg_read(3'd3, rd); chk("R8 write offset cleared", 128'(rd), 128'(0));
    reg_read(3'd2, rd); chk("R8 read offset cleared", 128'(rd), 128'(0));
    chk("R8 irq low when disabled", 128'(irq), 128'(0));
    reg_write(3'd2, 32'h20);
    reg_read(3'd2, rd); chk("R8 read offset write ignored", 128'(rd), 128'(0));

    // R4 lower clamp: size 0 acts as 32-byte ring
    set_ctrl(32'h0000_0007);
    send(128'h81); send(128'h92);
    reg_read(3'd3, rd); chk("R4 minimum ring wrap with overflow", 128'(rd), 128'(32'h8000_0000));
    // R4 upper clamp
    set_ctrl(32'h0000_1F07);
    set_rptr(32'hFFFF_FFF0);
    reg_read(3'd2, rd); chk("R4 maximum ring mask", 128'(rd), 128'(32'h0000_FFF0));

    repeat (4) @(negedge clk);
    chk("R7 scoreboard drained", 128'(q.size()), 128'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule